// File: doc/BRIEF.md
# Supply Voltage Sampling Controller

This block runs a successive-approximation measurement of the supply rail with 4 bits of resolution. It drives a trial code to an external reference ladder, reads back a single comparator bit, and resolves the code from the most significant bit to the least. It is paced by a 2048 Hz enable pulse, which is one clock-enable cycle every 1/2048 s. Software selects one of three modes through two control bits: off, automatic sampling once every four seconds, or back-to-back continuous sampling.

Software reads the run bit as a busy flag. The result register keeps its last value until a new conversion completes. A completed level of zero can raise a one-cycle internal reset request when a static option input enables it. A request to stop the oscillator is not granted while a conversion is running. Hardware clears both control bits while the request waits, and grants it once the result has been written.

Top module: `svd_sampler`

## Requirements
- R1: After the asynchronous active-low reset, `stat_busy_o`, `stat_sp_o`, `rst_req_o` and `osc_stop_ack_o` are 0, and `result_o` and `trial_o` are 0.
- R2: A completed conversion leaves in `result_o` the largest code L (0 to 15) for which the comparator reports the supply at or above L. `cmp_i` = 1 means the supply is at or above `trial_o`.
- R3: Bits are resolved MSB first. The first trial code is binary 1000. After 4 ticks that bit is kept if `cmp_i` = 1 and cleared otherwise, and bit 2 is set in the next trial code.
- R4: One conversion spans exactly 16 ticks of `tick_2k_i`, and `stat_busy_o` is 1 throughout.
- R5: `result_o` is written only when a conversion completes. During a conversion it shows the previous result.
- R6: Mode decode: `ctl_sp_i` = 0 selects off whatever `ctl_on_i` is. SP = 1 with ON = 0 selects automatic sampling. SP = 1 with ON = 1 selects continuous sampling. `stat_sp_o` returns the stored SP bit, and `stat_busy_o` returns 1 exactly while a conversion runs.
- R7: In continuous mode a new conversion begins in the completion cycle, so `stat_busy_o` stays 1 between conversions.
- R8: In automatic mode a conversion starts on an internal quarter-hertz pulse, which is one in every QTR_DIV ticks (8192 by default). A pulse arriving while busy is ignored.
- R9: A control write that selects off abandons a running conversion. `stat_busy_o` reads 0 on the next cycle, and `result_o` is not changed.
- R10: While `sleep_req_i` = 1 and a conversion runs, `osc_stop_ack_o` stays 0 and both control bits are cleared. The conversion completes, `osc_stop_ack_o` rises one cycle after `stat_busy_o` falls, and no new conversion starts.
- R11: With `sleep_req_i` = 1 while idle, `osc_stop_ack_o` rises on the next cycle. It falls one cycle after `sleep_req_i` drops.
- R12: When a conversion completes with code 0 and `lvl0_rst_en_i` = 1, `rst_req_o` pulses for exactly the one cycle in which the new result first shows. With `lvl0_rst_en_i` = 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_2k_i | input | 1 | One-cycle enable pulse at 2048 Hz |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_on_i | input | 1 | Run bit written with the strobe |
| ctl_sp_i | input | 1 | Sampling-enable bit written with the strobe |
| stat_busy_o | output | 1 | Run bit read value: 1 busy, 0 ready |
| stat_sp_o | output | 1 | Stored sampling-enable bit |
| result_o | output | RES_W | Last completed level |
| trial_o | output | RES_W | Trial code to the reference ladder (0 when idle) |
| cmp_i | input | 1 | Comparator: 1 when supply is at or above the trial level |
| lvl0_rst_en_i | input | 1 | Static option: allow reset request on level 0 |
| rst_req_o | output | 1 | One-cycle internal reset request |
| sleep_req_i | input | 1 | Oscillator stop request |
| osc_stop_ack_o | output | 1 | Oscillator stop granted |

## Verification
The main function is tried with a modelled supply at every one of the 16 levels. Each level is converted in automatic mode, so the final code, the second trial code, the tick count and the spacing between conversions are each checked against arithmetic. Level 0 is converted with the option set and again with it clear; this separates a correct reset request from one that is always on or never on. Continuous mode is run with a supply change partway through, which shows that conversions chain without a gap. Sleep requests arrive during a conversion and again while idle, and an off write lands mid-conversion, so that finishing a conversion, abandoning it and granting the stop are each told apart.

// File: rtl/svd_pkg.sv
package svd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_AUTO = 2'd1,
        MODE_CONT = 2'd2
    } svd_mode_e;

    // SP gates the circuit; ON picks continuous over automatic.
    function automatic svd_mode_e mode_of(input logic on_bit, input logic sp_bit);
        if (!sp_bit) begin
            return MODE_OFF;
        end
        if (on_bit) begin
            return MODE_CONT;
        end
        return MODE_AUTO;
    endfunction

endpackage

// File: rtl/svd_qtr_div.sv
module svd_qtr_div #(
    parameter int QTR_DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic qtick_o
);
    localparam int DIV_W = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(QTR_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } div_s;

    div_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (tick_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign qtick_o = s_q.pulse;

endmodule

// File: rtl/svd_sar_core.sv
module svd_sar_core #(
    parameter int RES_W  = 4,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic [RES_W-1:0] trial_o,
    output logic             done_o,
    output logic [RES_W-1:0] final_o
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam int SUB_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SETTLE - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
        logic [RES_W-1:0] code;
    } sar_s;

    sar_s             s_d, s_q;
    sar_s             fresh;
    logic             resolve;
    logic [RES_W-1:0] kept;

    always_comb begin
        fresh                  = '0;
        fresh.active           = 1'b1;
        fresh.idx              = TOP_IDX;
        fresh.code[RES_W-1]    = 1'b1;

        resolve = s_q.active && tick_i && (s_q.sub == LAST_SUB);
        kept    = s_q.code;
        if (!cmp_i) begin
            kept[s_q.idx] = 1'b0;
        end

        s_d     = s_q;
        done_o  = 1'b0;
        final_o = '0;

        if (abort_i) begin
            s_d = '0;
        end else if (resolve) begin
            if (s_q.idx == '0) begin
                done_o  = 1'b1;
                final_o = kept;
                if (start_i) begin
                    s_d = fresh;
                end else begin
                    s_d = '0;
                end
            end else begin
                s_d.idx                   = s_q.idx - IDX_W'(1);
                s_d.sub                   = '0;
                s_d.code                  = kept;
                s_d.code[s_q.idx - IDX_W'(1)] = 1'b1;
            end
        end else if (s_q.active && tick_i) begin
            s_d.sub = s_q.sub + SUB_W'(1);
        end else if (!s_q.active && start_i) begin
            s_d = fresh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = s_q.active;
    assign trial_o = s_q.code;

endmodule

// File: rtl/svd_ctrl.sv
module svd_ctrl
    import svd_pkg::*;
#(
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             on_i,
    input  logic             sp_i,
    input  logic             sleep_i,
    input  logic             lvl0_en_i,
    input  logic             busy_i,
    input  logic             qtick_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] final_i,
    output logic             start_o,
    output logic             abort_o,
    output logic             sp_o,
    output logic [RES_W-1:0] result_o,
    output logic             rst_req_o,
    output logic             ack_o
);
    typedef struct packed {
        logic             on_bit;
        logic             sp_bit;
        logic [RES_W-1:0] result;
        logic             rst_req;
        logic             ack;
    } ctl_s;

    ctl_s      s_d, s_q;
    svd_mode_e mode;

    always_comb begin
        mode    = mode_of(s_q.on_bit, s_q.sp_bit);
        start_o = !sleep_i &&
                  ((mode == MODE_CONT) ||
                   ((mode == MODE_AUTO) && qtick_i && !busy_i));
        abort_o = wr_i && !sp_i;

        s_d = s_q;
        if (wr_i) begin
            s_d.on_bit = on_i;
            s_d.sp_bit = sp_i;
        end
        if (sleep_i && busy_i) begin
            s_d.on_bit = 1'b0;
            s_d.sp_bit = 1'b0;
        end
        if (done_i) begin
            s_d.result = final_i;
        end
        s_d.rst_req = done_i && (final_i == '0) && lvl0_en_i;
        s_d.ack     = sleep_i && !busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sp_o      = s_q.sp_bit;
    assign result_o  = s_q.result;
    assign rst_req_o = s_q.rst_req;
    assign ack_o     = s_q.ack;

endmodule

// File: rtl/svd_sampler.sv
module svd_sampler #(
    parameter int RES_W        = 4,
    parameter int SETTLE_TICKS = 4,
    parameter int QTR_DIV      = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_2k_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_on_i,
    input  logic             ctl_sp_i,
    output logic             stat_busy_o,
    output logic             stat_sp_o,
    output logic [RES_W-1:0] result_o,
    output logic [RES_W-1:0] trial_o,
    input  logic             cmp_i,
    input  logic             lvl0_rst_en_i,
    output logic             rst_req_o,
    input  logic             sleep_req_i,
    output logic             osc_stop_ack_o
);
    logic             qtick;
    logic             start;
    logic             abort;
    logic             busy;
    logic             done;
    logic [RES_W-1:0] final_code;

    svd_qtr_div #(
        .QTR_DIV (QTR_DIV)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_2k_i),
        .qtick_o (qtick)
    );

    svd_sar_core #(
        .RES_W  (RES_W),
        .SETTLE (SETTLE_TICKS)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_2k_i),
        .start_i (start),
        .abort_i (abort),
        .cmp_i   (cmp_i),
        .busy_o  (busy),
        .trial_o (trial_o),
        .done_o  (done),
        .final_o (final_code)
    );

    svd_ctrl #(
        .RES_W (RES_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctl_wr_i),
        .on_i      (ctl_on_i),
        .sp_i      (ctl_sp_i),
        .sleep_i   (sleep_req_i),
        .lvl0_en_i (lvl0_rst_en_i),
        .busy_i    (busy),
        .qtick_i   (qtick),
        .done_i    (done),
        .final_i   (final_code),
        .start_o   (start),
        .abort_o   (abort),
        .sp_o      (stat_sp_o),
        .result_o  (result_o),
        .rst_req_o (rst_req_o),
        .ack_o     (osc_stop_ack_o)
    );

    assign stat_busy_o = busy;

endmodule

// File: rtl/svd_sampler_chk.sv
module svd_sampler_chk #(
    parameter int RES_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr_i,
    input logic             ctl_sp_i,
    input logic             stat_busy_o,
    input logic             stat_sp_o,
    input logic [RES_W-1:0] result_o,
    input logic [RES_W-1:0] trial_o,
    input logic             lvl0_rst_en_i,
    input logic             rst_req_o,
    input logic             sleep_req_i,
    input logic             osc_stop_ack_o
);
    localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> $past(stat_busy_o));

    p_first_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_busy_o) |-> (trial_o == FIRST_TRIAL));

    p_off_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !ctl_sp_i) |=> !stat_busy_o);

    p_sleep_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req_i && stat_busy_o) |=> !stat_sp_o);

    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop_ack_o |-> !stat_busy_o);

    p_rstreq_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ((result_o == '0) && lvl0_rst_en_i));

    p_rstreq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

endmodule

bind svd_sampler svd_sampler_chk #(
    .RES_W (RES_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_wr_i       (ctl_wr_i),
    .ctl_sp_i       (ctl_sp_i),
    .stat_busy_o    (stat_busy_o),
    .stat_sp_o      (stat_sp_o),
    .result_o       (result_o),
    .trial_o        (trial_o),
    .lvl0_rst_en_i  (lvl0_rst_en_i),
    .rst_req_o      (rst_req_o),
    .sleep_req_i    (sleep_req_i),
    .osc_stop_ack_o (osc_stop_ack_o)
);

// File: tb/tb_svd_sampler.sv
module tb_svd_sampler;
    localparam int RES_W    = 4;
    localparam int QTR_DIV  = 32;
    localparam int TICK_PER = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_2k;
    logic [1:0]       tcnt;
    logic             ctl_wr = 1'b0, ctl_on = 1'b0, ctl_sp = 1'b0;
    logic             stat_busy_o, stat_sp_o, rst_req_o, osc_stop_ack_o;
    logic [RES_W-1:0] result_o, trial_o;
    logic             cmp;
    logic             lvl0_en = 1'b1;
    logic             sleep_req = 1'b0;
    int               vlevel = 0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            tick_2k <= 1'b0;
        end else begin
            tcnt    <= tcnt + 2'd1;
            tick_2k <= (tcnt == 2'd3);
        end
    end

    // Comparator model: supply at or above the trial level.
    always_comb cmp = (vlevel >= int'(trial_o));

    svd_sampler #(
        .RES_W        (RES_W),
        .SETTLE_TICKS (4),
        .QTR_DIV      (QTR_DIV)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_2k_i      (tick_2k),
        .ctl_wr_i       (ctl_wr),
        .ctl_on_i       (ctl_on),
        .ctl_sp_i       (ctl_sp),
        .stat_busy_o    (stat_busy_o),
        .stat_sp_o      (stat_sp_o),
        .result_o       (result_o),
        .trial_o        (trial_o),
        .cmp_i          (cmp),
        .lvl0_rst_en_i  (lvl0_en),
        .rst_req_o      (rst_req_o),
        .sleep_req_i    (sleep_req),
        .osc_stop_ack_o (osc_stop_ack_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic on_b, input logic sp_b);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_on = on_b;
        ctl_sp = sp_b;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_busy(input logic lvl, input string tag);
        int n = 0;
        while (stat_busy_o !== lvl && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk(1'b0, tag, int'(stat_busy_o), int'(lvl));
    endtask

    task automatic idle_window(input int cycles, input string tag);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (stat_busy_o) hits++;
        end
        chk(hits == 0, tag, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        int ticks;
        int last_rise;
        int now;
        int lows;
        bit seen2;
        now = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(stat_busy_o == 0 && stat_sp_o == 0 && rst_req_o == 0 && osc_stop_ack_o == 0,
            "R1 flags", int'({stat_busy_o, stat_sp_o, rst_req_o, osc_stop_ack_o}), 0);
        chk(result_o == 0 && trial_o == 0, "R1 result/trial", int'({result_o, trial_o}), 0);
        rst_n = 1'b1;

        // R6: SP=0 is off even with ON=1
        wr_ctl(1'b1, 1'b0);
        idle_window(300, "R6 off with on=1");
        chk(stat_sp_o == 1'b0, "R6 sp readback off", int'(stat_sp_o), 0);

        // Sweep all levels in automatic mode
        wr_ctl(1'b0, 1'b1);
        @(negedge clk);
        chk(stat_sp_o == 1'b1, "R6 sp readback on", int'(stat_sp_o), 1);
        prev = 0;
        last_rise = -1;
        for (int v = 0; v < 16; v++) begin
            wait_busy(1'b0, "R6 idle before level");
            vlevel = v;
            ticks = 0;
            while (!stat_busy_o) begin
                @(negedge clk);
                now++;
            end
            // counted from the first negedge after start
            chk(trial_o == 4'b1000, "R3 first trial", int'(trial_o), 8);
            if (last_rise >= 0)
                chk(now - last_rise == QTR_DIV * TICK_PER, "R8 auto period",
                    now - last_rise, QTR_DIV * TICK_PER);
            last_rise = now;
            seen2 = 1'b0;
            while (stat_busy_o) begin
                if (tick_2k) ticks++;
                if (ticks == 8)
                    chk(result_o == prev[RES_W-1:0], "R5 hold during conversion",
                        int'(result_o), prev);
                @(negedge clk);
                now++;
                if (!seen2 && stat_busy_o && trial_o != 4'b1000) begin
                    seen2 = 1'b1;
                    chk(ticks == 4, "R3 bit period", ticks, 4);
                    chk(int'(trial_o) == ((v & 8) | 4), "R3 second trial",
                        int'(trial_o), (v & 8) | 4);
                end
            end
            chk(ticks == 16, "R4 conversion ticks", ticks, 16);
            chk(int'(result_o) == v, "R2 result level", int'(result_o), v);
            chk(rst_req_o == (v == 0), "R12 level0 pulse", int'(rst_req_o), int'(v == 0));
            @(negedge clk);
            now++;
            chk(rst_req_o == 1'b0, "R12 pulse width", int'(rst_req_o), 0);
            prev = v;
        end

        // R12: option cleared suppresses the request
        lvl0_en = 1'b0;
        vlevel = 0;
        wait_busy(1'b1, "R8 auto restart");
        wait_busy(1'b0, "R4 auto finish");
        chk(result_o == 0, "R2 level0 result", int'(result_o), 0);
        chk(rst_req_o == 1'b0, "R12 option off", int'(rst_req_o), 0);
        lvl0_en = 1'b1;

        // R7: continuous mode keeps busy high and restarts
        vlevel = 9;
        wr_ctl(1'b1, 1'b1);
        wait_busy(1'b1, "R7 start");
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!stat_busy_o) lows++;
        end
        chk(lows == 0, "R7 busy gaps", lows, 0);
        chk(result_o == 9, "R7 result", int'(result_o), 9);
        vlevel = 5;
        repeat (40 * TICK_PER) @(negedge clk);
        chk(result_o == 5 && stat_busy_o, "R7 follows change", int'(result_o), 5);

        // R10: sleep during a conversion
        vlevel = 6;
        for (int i = 0; i < 400 && result_o != 6; i++) @(negedge clk);
        vlevel = 2;
        repeat (3 * TICK_PER) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        chk(stat_sp_o == 1'b0, "R10 bits cleared", int'(stat_sp_o), 0);
        lows = 0;
        while (stat_busy_o) begin
            if (osc_stop_ack_o) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R10 ack withheld", lows, 0);
        chk(osc_stop_ack_o == 1'b0, "R10 ack lag", int'(osc_stop_ack_o), 0);
        chk(result_o == 2, "R10 conversion finished", int'(result_o), 2);
        @(negedge clk);
        chk(osc_stop_ack_o == 1'b1, "R10 ack granted", int'(osc_stop_ack_o), 1);
        idle_window(200, "R10 no restart");
        sleep_req = 1'b0;
        @(negedge clk);
        chk(osc_stop_ack_o == 1'b0, "R11 ack drop", int'(osc_stop_ack_o), 0);

        // R11: sleep while idle
        sleep_req = 1'b1;
        @(negedge clk);
        chk(osc_stop_ack_o == 1'b1, "R11 idle ack", int'(osc_stop_ack_o), 1);
        sleep_req = 1'b0;
        @(negedge clk);

        // R9: off write abandons a conversion
        vlevel = 11;
        wr_ctl(1'b0, 1'b1);
        wait_busy(1'b1, "R9 start");
        repeat (6 * TICK_PER) @(negedge clk);
        wr_ctl(1'b0, 1'b0);
        chk(stat_busy_o == 1'b0, "R9 busy drops", int'(stat_busy_o), 0);
        chk(result_o == 2, "R9 result kept", int'(result_o), 2);
        idle_window(200, "R9 stays off");
        chk(result_o == 2, "R9 result after", int'(result_o), 2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule